// File: doc/BRIEF.md
# Flash Reset and Power-Up Sequencer

This block sits on the host side of a parallel NOR flash. It drives the flash's active-low hardware reset pin and tells the host when it may begin read cycles and, later, write cycles. It holds the flash in reset while the supply is not good. Once power becomes valid, it keeps reset low for the full supply setup interval. On a software request it issues a reset pulse and then withholds access until the device can accept commands again.

The width of a software reset pulse, and the time before access is allowed again, both depend on whether the flash was running an embedded program or erase algorithm. The host's busy flag is sampled on the clock edge that accepts the request. That sample selects the long timing (10 us pulse, 20 us ready) or the short timing (500 ns pulse, 500 ns ready). After release, reset must stay high for at least 50 ns before a read. Writes wait a further 50 ns after reads are allowed, which covers the ready/busy recovery to write-enable. Every interval is given in nanoseconds and converted to whole clock cycles, rounded up, from a clock-period parameter.

Top module: `flash_rst_seq`

## Requirements
- R1: While `rst_n` is low, or after any cycle in which `pwr_good` is sampled low, `flash_rst_n`, `rd_ok` and `wr_ok` are all 0. A drop of `pwr_good` takes effect on the following clock edge from any state.
- R2: After `pwr_good` is first sampled high, `flash_rst_n` stays low for exactly ceil(50000 ns / period) further cycles.
- R3: A request accepted with `algo_busy` = 0 gives a low pulse of exactly ceil(500 ns / period) cycles, starting the cycle after acceptance.
- R4: A request accepted with `algo_busy` = 1 gives a low pulse of exactly ceil(10000 ns / period) cycles.
- R5: `algo_busy` matters only on the accepting edge. Changing it during the pulse or the recovery does not change any timing.
- R6: `rd_ok` rises max(ceil(ready)-pulse, ceil(50 ns / period)) cycles after `flash_rst_n` rises. Here ready is 20000 ns for long timing and 500 ns for short timing and for power-up, and pulse is the low length in cycles.
- R7: `wr_ok` rises exactly ceil(50 ns / period) cycles after `rd_ok` rises.
- R8: `sw_rst_req` is ignored while `flash_rst_n` is low, while recovery is in progress (`wr_ok` = 0) and while power is not good. `flash_rst_n` can fall only from a state with `wr_ok` = 1 or on a loss of power.
- R9: Once `wr_ok` is 1, `rd_ok` and `flash_rst_n` are also 1. All three stay high until the next accepted request or a loss of power.

Every interval in R2 to R7 is rounded up to whole cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sequencer clock |
| rst_n | input | 1 | Asynchronous active-low reset of the sequencer |
| pwr_good | input | 1 | Supply valid indication |
| sw_rst_req | input | 1 | Software request for a flash reset pulse |
| algo_busy | input | 1 | High while the flash runs an embedded program or erase |
| flash_rst_n | output | 1 | Drive for the flash's active-low reset pin |
| rd_ok | output | 1 | Host may issue read cycles |
| wr_ok | output | 1 | Host may issue write cycles |

## Verification
If the sequencer latches the wrong timing mode or miscounts, the fault shows as a wrong number of low cycles on `flash_rst_n` within one pulse, or as a wrong gap before `rd_ok` or `wr_ok`. Each is visible within 20 us of the request. A state that wrongly accepts a request during recovery shows up as an extra falling edge of the reset pin. A flag that is sampled at the wrong time shows up as a short pulse growing into a long one. A missed power-loss path shows up one cycle after `pwr_good` drops, as a reset pin or permission that stays high.

// File: rtl/flash_rst_seq.sv
module flash_rst_seq #(
  parameter int CLK_PS       = 4000,
  parameter int VCS_NS       = 50000,
  parameter int RP_LONG_NS   = 10000,
  parameter int RP_SHORT_NS  = 500,
  parameter int RH_NS        = 50,
  parameter int RDY_LONG_NS  = 20000,
  parameter int RDY_SHORT_NS = 500,
  parameter int WREC_NS      = 50
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwr_good,
  input  logic sw_rst_req,
  input  logic algo_busy,
  output logic flash_rst_n,
  output logic rd_ok,
  output logic wr_ok
);

  function automatic int cyc(input longint ns);
    longint c;
    c = (ns * 1000 + CLK_PS - 1) / CLK_PS;
    return (c < 1) ? 1 : int'(c);
  endfunction

  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int N_VCS  = cyc(VCS_NS);
  localparam int N_RPL  = cyc(RP_LONG_NS);
  localparam int N_RPS  = cyc(RP_SHORT_NS);
  localparam int N_RH   = cyc(RH_NS);
  localparam int N_RDYL = cyc(RDY_LONG_NS);
  localparam int N_RDYS = cyc(RDY_SHORT_NS);
  localparam int N_WR   = cyc(WREC_NS);
  localparam int REL_P  = mx(N_RDYS - N_VCS, N_RH);
  localparam int REL_L  = mx(N_RDYL - N_RPL, N_RH);
  localparam int REL_S  = mx(N_RDYS - N_RPS, N_RH);
  localparam int CW     = $clog2(mx(mx(N_VCS, N_RPL), REL_L + N_WR) + 2);

  typedef enum logic [1:0] {S_OFF, S_LOW, S_REC, S_IDLE} st_t;
  typedef enum logic [1:0] {M_PWR, M_SHORT, M_LONG} md_t;

  st_t st;
  md_t md;
  logic [CW-1:0] cnt, len, rel_rd, rel_wr;

  always_comb begin
    case (md)
      M_LONG:  begin len = CW'(N_RPL); rel_rd = CW'(REL_L); end
      M_SHORT: begin len = CW'(N_RPS); rel_rd = CW'(REL_S); end
      default: begin len = CW'(N_VCS); rel_rd = CW'(REL_P); end
    endcase
    rel_wr = rel_rd + CW'(N_WR);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= S_OFF;
      md  <= M_PWR;
      cnt <= '0;
    end else if (!pwr_good) begin
      st  <= S_OFF;
      cnt <= '0;
    end else begin
      case (st)
        S_OFF: begin
          st  <= S_LOW;
          md  <= M_PWR;
          cnt <= '0;
        end
        S_LOW: begin
          if (cnt == len - 1'b1) begin
            st  <= S_REC;
            cnt <= '0;
          end else cnt <= cnt + 1'b1;
        end
        S_REC: begin
          if (cnt == rel_wr - 1'b1) begin
            st  <= S_IDLE;
            cnt <= '0;
          end else cnt <= cnt + 1'b1;
        end
        default: begin
          if (sw_rst_req) begin
            st  <= S_LOW;
            md  <= algo_busy ? M_LONG : M_SHORT;
            cnt <= '0;
          end
        end
      endcase
    end
  end

  assign flash_rst_n = (st == S_REC) || (st == S_IDLE);
  assign rd_ok       = (st == S_IDLE) || ((st == S_REC) && (cnt >= rel_rd));
  assign wr_ok       = (st == S_IDLE);

endmodule

// File: rtl/flash_rst_seq_chk.sv
module flash_rst_seq_chk #(
  parameter int CLK_PS      = 4000,
  parameter int RP_SHORT_NS = 500
) (
  input logic clk,
  input logic rst_n,
  input logic pwr_good,
  input logic flash_rst_n,
  input logic rd_ok,
  input logic wr_ok
);
  localparam int N_MIN = int'((longint'(RP_SHORT_NS) * 1000 + CLK_PS - 1) / CLK_PS);
  localparam int LW = $clog2(N_MIN + 2) + 1;

  logic [LW-1:0] low_run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) low_run <= '0;
    else if (flash_rst_n) low_run <= '0;
    else if (low_run != {LW{1'b1}}) low_run <= low_run + 1'b1;
  end

  a_r1_power_loss: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_good |=> (!flash_rst_n && !rd_ok && !wr_ok));
  a_r3_min_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flash_rst_n) |-> (int'(low_run) >= N_MIN));
  a_r6_read_after_release: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_ok) |-> flash_rst_n);
  a_r7_write_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_ok) |-> $past(rd_ok));
  a_r8_fall_only_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flash_rst_n) |-> ($past(wr_ok) || !$past(pwr_good)));
  a_r9_write_implies_read: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ok |-> (rd_ok && flash_rst_n));
endmodule

bind flash_rst_seq flash_rst_seq_chk #(.CLK_PS(CLK_PS), .RP_SHORT_NS(RP_SHORT_NS)) u_chk (
  .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good),
  .flash_rst_n(flash_rst_n), .rd_ok(rd_ok), .wr_ok(wr_ok)
);

// File: tb/sim_flash_rst_seq.sv
`timescale 1ns/1ps
module sim_flash_rst_seq;
  localparam int P = 4000;

  function automatic int cy(input int ns);
    return (ns * 1000 + P - 1) / P;
  endfunction
  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int E_VCS = cy(50000);
  localparam int E_RPL = cy(10000);
  localparam int E_RPS = cy(500);
  localparam int E_RH  = cy(50);
  localparam int E_WR  = cy(50);
  localparam int E_RDP = mx(cy(500) - E_VCS, E_RH);
  localparam int E_RDL = mx(cy(20000) - E_RPL, E_RH);
  localparam int E_RDS = mx(cy(500) - E_RPS, E_RH);

  logic clk = 0, rst_n = 0, pwr_good = 0, sw_rst_req = 0, algo_busy = 0;
  logic flash_rst_n, rd_ok, wr_ok;
  int errors = 0, checks = 0;
  bit done = 0;

  always #2 clk = ~clk;

  flash_rst_seq #(.CLK_PS(P)) u0 (
    .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good), .sw_rst_req(sw_rst_req),
    .algo_busy(algo_busy), .flash_rst_n(flash_rst_n), .rd_ok(rd_ok), .wr_ok(wr_ok)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Entered at the first negedge that observes the reset pin low.
  task automatic measure(input int e_low, input int e_rd, input string tag,
                         input bit poke, input bit flip_flag);
    int n_low = 0, n_rd = 0, n_wr = 0, bad = 0;
    while (!flash_rst_n && n_low < 20000) begin
      if (rd_ok || wr_ok) bad++;
      sw_rst_req = poke && (n_low == 3);
      if (flip_flag && n_low == 1) algo_busy = 1;
      n_low++;
      @(negedge clk);
    end
    while (!rd_ok && n_rd < 20000) begin
      if (!flash_rst_n || wr_ok) bad++;
      sw_rst_req = poke && (n_rd == 1);
      n_rd++;
      @(negedge clk);
    end
    while (!wr_ok && n_wr < 20000) begin
      sw_rst_req = poke && (n_wr == 0);
      n_wr++;
      @(negedge clk);
    end
    sw_rst_req = 0;
    algo_busy = 0;
    chk({tag, " pulse length"}, n_low, e_low);
    chk({"R6 ", tag, " read delay"}, n_rd, e_rd);
    chk({"R7 ", tag, " write delay"}, n_wr, E_WR);
    chk({"R9 ", tag, " no early permission"}, bad, 0);
  endtask

  task automatic request(input bit busy);
    sw_rst_req = 1;
    algo_busy = busy;
    @(negedge clk);
    sw_rst_req = 0;
    algo_busy = 0;
  endtask

  task automatic hold_idle(input string tag, input int n);
    int bad = 0;
    for (int i = 0; i < n; i++) begin
      if (!flash_rst_n || !rd_ok || !wr_ok) bad++;
      @(negedge clk);
    end
    chk(tag, bad, 0);
  endtask

  task automatic power_up(input string tag);
    pwr_good = 1;
    @(negedge clk);
    measure(E_VCS, E_RDP, {"R2 ", tag}, 0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset pin in reset", flash_rst_n, 0);
    chk("R1 read in reset", rd_ok, 0);
    chk("R1 write in reset", wr_ok, 0);
    rst_n = 1;
    sw_rst_req = 1;
    repeat (5) @(negedge clk);
    sw_rst_req = 0;
    chk("R8 request ignored without power", flash_rst_n, 0);
    power_up("power-up");
    hold_idle("R9 permission holds", 20);

    for (int b = 0; b < 2; b++) begin
      for (int r = 0; r < 2; r++) begin
        request(b[0]);
        chk("R3 R4 pin low after accept", flash_rst_n, 0);
        if (b == 0) measure(E_RPS, E_RDS, "R3 short", 0, 0);
        else        measure(E_RPL, E_RDL, "R4 long", 0, 0);
        hold_idle("R9 idle after sequence", 4 + r);
      end
    end

    request(0);
    measure(E_RPS, E_RDS, "R5 flag raised after accept", 0, 1);
    hold_idle("R5 idle", 5);

    request(0);
    measure(E_RPS, E_RDS, "R8 short with pokes", 1, 0);
    hold_idle("R8 poke not accepted", 30);
    request(1);
    measure(E_RPL, E_RDL, "R8 long with pokes", 1, 0);
    hold_idle("R8 poke not accepted long", 30);

    request(0);
    while (!flash_rst_n) @(negedge clk);
    repeat (3) @(negedge clk);
    pwr_good = 0;
    @(negedge clk);
    chk("R1 pin after power loss in recovery", flash_rst_n, 0);
    chk("R1 read after power loss", rd_ok, 0);
    chk("R1 write after power loss", wr_ok, 0);
    repeat (4) @(negedge clk);
    power_up("re-power");

    pwr_good = 0;
    @(negedge clk);
    chk("R1 pin after power loss when idle", flash_rst_n, 0);
    chk("R1 write after power loss when idle", wr_ok, 0);
    power_up("re-power idle");

    request(1);
    repeat (10) @(negedge clk);
    pwr_good = 0;
    @(negedge clk);
    chk("R1 power loss in pulse", rd_ok | wr_ok | flash_rst_n, 0);
    power_up("re-power pulse");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule